// File: doc/BRIEF.md
# Integer Replacement Step Counter

This engine computes the least number of unit operations that bring a positive integer down to 1. There are three operations: halving an even value, adding one to an odd value, and subtracting one from an odd value. A caller places the value on the input bus and pulses start. The engine then reports the count together with a one-cycle completion pulse.

The engine does not apply one operation per clock. Each iteration removes a complete run of equal low-order bits. An even value loses all of its trailing zeros in a single shift. An odd value that ends in two or more ones, and that is larger than 3, is incremented, and the zeros that the increment produces are shifted out in the same iteration. Every other odd value is decremented and halved. Both run lengths come from the same counter: a left-smeared copy of the operand followed by a population count. That counter is instantiated twice, and one of the two copies sees the inverted word.

Top module: `intrep_engine`

## Requirements
- R1: While reset is held and in the first cycle after it, busy and done are 0 and result is 0.
- R2: An input of 1 gives a result of 0. done rises on the first clock edge after the edge that accepted start.
- R3: An even value loses its whole trailing-zero run in one iteration, and the run length is added to the count, so 2^k gives k (8 gives 3, 4 gives 2, 2 gives 1).
- R4: An odd value above 3 that ends in two or more ones is incremented and then shifted right by its trailing-ones length, which adds that length plus one (7 gives 4, 0x00FFF000 gives 25).
- R5: Any other odd value, including 3, is decremented and halved, which adds 2 (3 gives 2, 5 gives 3, 0x7F000800 gives 33).
- R6: A word of all ones (DATA_W ones) finishes at once with a result of DATA_W+1, which is 33 for 32 bits. done follows one edge after acceptance.
- R7: start is accepted only while busy is 0. A start asserted while busy is ignored and does not change the running result.
- R8: busy is 1 from the accepting edge until the edge that raises done. done lasts exactly one cycle, and done and busy are never 1 together.
- R9: result keeps its value from one done pulse until the next.
- R10: Each clock performs one run-consuming iteration. done therefore rises n+1 edges after acceptance, where n is the number of iterations (0x7F000800: 5 edges, 0x00FFF000: 3 edges, 8: 2 edges).
- R11: For every input from 1 to 2^31-1, the result equals the minimum number of single operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request to begin; sampled only while idle |
| value_in | input | DATA_W | Starting value, captured when start is accepted |
| busy | output | 1 | High while a computation is in progress |
| done | output | 1 | One-cycle pulse marking result as new |
| result | output | CNT_W | Operation count, where CNT_W = clog2(2*DATA_W+2) |

## Verification
The bench builds the engine with the default DATA_W of 32, which makes CNT_W 7. With this width the all-ones word can be checked against its fixed answer of 33. Increments that carry into bit 31 are exercised (0x7FFFFFFF), along with long runs of trailing zeros and trailing ones. A reference model inside the bench applies one single operation per step. It is compared against the engine over a dense sweep of small values and a pseudo-random spread of 31-bit values. Known inputs also have their done latency checked edge by edge.

// File: rtl/intrep_pkg.sv
// Shared types for the integer replacement engine.
package intrep_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } intrep_state_e;
endpackage

// File: rtl/intrep_trail_cnt.sv
// Counts the trailing run of zeros (INVERT=0) or ones (INVERT=1) in vec.
// The operand is smeared toward the MSB with a log-depth chain of OR-shifts.
// The count is DATA_W minus the popcount of the smeared word.
// Assumes DATA_W >= 2. An all-zero operand (after optional inversion) gives DATA_W.
module intrep_trail_cnt #(
    parameter int DATA_W = 32,
    parameter bit INVERT = 1'b0,
    localparam int SH_W = $clog2(DATA_W + 1)
) (
    input  logic [DATA_W-1:0] vec,
    output logic [SH_W-1:0]   cnt
);
    localparam int STAGES = $clog2(DATA_W);

    logic [DATA_W-1:0] smear [0:STAGES];
    logic [SH_W-1:0]   pop;

    // Select the true or inverted operand as the first smear stage.
    generate
        if (INVERT) begin : g_inv
            assign smear[0] = ~vec;
        end else begin : g_true
            assign smear[0] = vec;
        end
    endgenerate

    // Each stage ORs in a copy shifted left by a power of two.
    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_smear
            assign smear[g+1] = smear[g] | (smear[g] << (1 << g));
        end
    endgenerate

    // Population count of the fully smeared word.
    always_comb begin
        pop = '0;
        for (int i = 0; i < DATA_W; i++) begin
            pop = pop + SH_W'(smear[STAGES][i]);
        end
    end

    // Bits below the lowest set bit stay clear after smearing.
    assign cnt = SH_W'(DATA_W) - pop;
endmodule

// File: rtl/intrep_step.sv
// One run-consuming iteration of the replacement rule, as pure logic.
// Given the current value it reports: finish (value is 1), all_ones (the
// special word), the next value, and the amount to add to the count.
// Assumes cur is non-zero.
module intrep_step #(
    parameter int DATA_W = 32,
    localparam int CNT_W = $clog2(2 * DATA_W + 2),
    localparam int SH_W  = $clog2(DATA_W + 1)
) (
    input  logic [DATA_W-1:0] cur,
    output logic              is_one,
    output logic              all_ones,
    output logic [DATA_W-1:0] nxt,
    output logic [CNT_W-1:0]  inc
);
    logic [SH_W-1:0]   tz_len;
    logic [SH_W-1:0]   to_len;
    logic [DATA_W:0]   bumped;
    logic [DATA_W:0]   bumped_sh;
    logic [DATA_W-1:0] dec_half;

    intrep_trail_cnt #(.DATA_W(DATA_W), .INVERT(1'b0)) u_tz (
        .vec (cur),
        .cnt (tz_len)
    );

    intrep_trail_cnt #(.DATA_W(DATA_W), .INVERT(1'b1)) u_to (
        .vec (cur),
        .cnt (to_len)
    );

    assign is_one   = (cur == DATA_W'(1));
    assign all_ones = (to_len == SH_W'(DATA_W));

    // Increment at one extra bit so a carry out of the MSB survives the shift.
    assign bumped    = {1'b0, cur} + (DATA_W+1)'(1);
    assign bumped_sh = bumped >> to_len;
    assign dec_half  = (cur - DATA_W'(1)) >> 1;

    // Choose the run to consume and the count to add.
    always_comb begin
        if (!cur[0]) begin
            nxt = cur >> tz_len;
            inc = CNT_W'(tz_len);
        end else if ((to_len > SH_W'(1)) && (cur > DATA_W'(3))) begin
            nxt = bumped_sh[DATA_W-1:0];
            inc = CNT_W'(to_len) + CNT_W'(1);
        end else begin
            nxt = dec_half;
            inc = CNT_W'(2);
        end
    end
endmodule

// File: rtl/intrep_engine.sv
// Integer replacement step counter. Accepts a value on start while idle,
// removes one run of trailing zeros or ones per clock, and pulses done
// with the minimum operation count. Inputs below 1 are not supported.
module intrep_engine #(
    parameter int DATA_W = 32,
    localparam int CNT_W = $clog2(2 * DATA_W + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] value_in,
    output logic              busy,
    output logic              done,
    output logic [CNT_W-1:0]  result
);
    import intrep_pkg::*;

    localparam logic [CNT_W-1:0] ALL_ONES_CNT = CNT_W'(DATA_W + 1);

    intrep_state_e     state_q;
    logic [DATA_W-1:0] val_q;
    logic [CNT_W-1:0]  acc_q;

    logic              st_is_one;
    logic              st_all_ones;
    logic [DATA_W-1:0] st_nxt;
    logic [CNT_W-1:0]  st_inc;
    logic              finish;

    intrep_step #(.DATA_W(DATA_W)) u_step (
        .cur      (val_q),
        .is_one   (st_is_one),
        .all_ones (st_all_ones),
        .nxt      (st_nxt),
        .inc      (st_inc)
    );

    assign finish = st_is_one | st_all_ones;

    // Sequencer: accept while idle, iterate once per clock, publish on finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            val_q   <= '0;
            acc_q   <= '0;
            busy    <= 1'b0;
            done    <= 1'b0;
            result  <= '0;
        end else begin
            done <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        val_q   <= value_in;
                        acc_q   <= '0;
                        busy    <= 1'b1;
                        state_q <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (finish) begin
                        result  <= st_all_ones ? ALL_ONES_CNT : acc_q;
                        done    <= 1'b1;
                        busy    <= 1'b0;
                        state_q <= ST_IDLE;
                    end else begin
                        val_q <= st_nxt;
                        acc_q <= acc_q + st_inc;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R8: completion and activity never overlap.
    assert_done_not_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R8: done is a single-cycle pulse.
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: result moves only together with a done pulse.
    assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> done);

    // R10: every non-final iteration strictly shrinks the working value.
    assert_progress_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !finish) |=> (val_q < $past(val_q)));

    // R10: a non-final iteration always adds a non-zero amount.
    assert_inc_nonzero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !finish) |-> (st_inc != '0));

    // R7: a start seen while busy does not replace the working value.
    assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !finish) |=> (busy && (val_q == $past(st_nxt))));
endmodule

// File: tb/intrep_engine_tb.sv
// Directed bench for intrep_engine; each task checks its own scenario.
module intrep_engine_tb;
    localparam int DATA_W = 32;
    localparam int CNT_W  = $clog2(2 * DATA_W + 2);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [DATA_W-1:0] value_in = '0;
    logic              busy;
    logic              done;
    logic [CNT_W-1:0]  result;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    intrep_engine #(.DATA_W(DATA_W)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .value_in (value_in),
        .busy     (busy),
        .done     (done),
        .result   (result)
    );

    always #5 clk = ~clk;

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_fail   = n_fail + 1;
            n_checks = n_checks + 1;
            $display("FAIL watchdog: actual %0d cycles, expected completion", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Reference: minimum count by single operations.
    function automatic int ref_steps(input longint v);
        int n = 0;
        while (v != 1) begin
            if (v[0] == 1'b0) v = v >> 1;
            else if (v == 3 || (v & 3) == 1) v = v - 1;
            else v = v + 1;
            n++;
        end
        return n;
    endfunction

    // Start a run and wait for done; returns the latency in edges after acceptance.
    task automatic run_one(input logic [DATA_W-1:0] v, output int lat, output int res);
        @(negedge clk);
        value_in = v;
        start    = 1'b1;
        @(posedge clk);
        #1;
        start = 1'b0;
        check(busy == 1'b1, "R8 busy after accept", busy, 1);
        lat = 0;
        do begin
            @(posedge clk);
            #1;
            lat++;
            if (!done) check(busy == 1'b1, "R8 busy until done", busy, 1);
        end while (!done && lat < 200);
        check(done == 1'b1, "R10 done arrived", done, 1);
        check(busy == 1'b0, "R8 busy low with done", busy, 0);
        res = int'(result);
        @(posedge clk);
        #1;
        check(done == 1'b0, "R8 done one cycle", done, 0);
        check(int'(result) == res, "R9 result held", result, res);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check(busy == 1'b0 && done == 1'b0, "R1 reset flags", {busy, done}, 0);
        check(result == '0, "R1 reset result", result, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check(busy == 1'b0 && done == 1'b0 && result == '0, "R1 after reset", result, 0);
    endtask

    task automatic t_known(input logic [DATA_W-1:0] v, input int exp, input int exp_lat, input string tag);
        int lat, res;
        run_one(v, lat, res);
        check(res == exp, tag, res, exp);
        if (exp_lat > 0) check(lat == exp_lat, "R10 latency", lat, exp_lat);
    endtask

    task automatic t_busy_start_R7();
        int lat;
        @(negedge clk);
        value_in = 32'h7F00_0800;
        start    = 1'b1;
        @(posedge clk);
        #1;
        start = 1'b0;
        @(negedge clk);
        value_in = 32'd2;
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 200) begin
            @(posedge clk);
            #1;
            lat++;
            if (done) break;
        end
        if (!done) begin
            @(posedge clk);
            #1;
        end
        check(int'(result) == 33, "R7 start while busy ignored", result, 33);
        check(lat == 5, "R7 latency unchanged", lat, 5);
        @(posedge clk);
        #1;
        check(busy == 1'b0, "R7 no queued start", busy, 0);
    endtask

    task automatic t_sweep_R11();
        logic [30:0] lfsr = 31'h1234_567;
        int lat, res, exp;
        for (int v = 1; v <= 400; v++) begin
            run_one(DATA_W'(v), lat, res);
            exp = ref_steps(longint'(v));
            check(res == exp, "R11 small sweep", res, exp);
        end
        for (int k = 0; k < 60; k++) begin
            lfsr = {lfsr[29:0], lfsr[30] ^ lfsr[27]};
            run_one({1'b0, lfsr}, lat, res);
            exp = ref_steps(longint'(lfsr));
            check(res == exp, "R11 wide sweep", res, exp);
        end
    endtask

    initial begin
        t_reset();
        t_known(32'd1, 0, 1, "R2 input one");
        t_known(32'd8, 3, 2, "R3 eight");
        t_known(32'd4, 2, 0, "R3 four");
        t_known(32'd2, 1, 0, "R3 two");
        t_known(32'h8000_0000, 31, 2, "R3 top bit");
        t_known(32'd7, 4, 2, "R4 seven");
        t_known(32'h00FF_F000, 25, 3, "R4 run of ones");
        t_known(32'h7FFF_FFFF, 32, 0, "R4 carry to msb");
        t_known(32'd3, 2, 2, "R5 three");
        t_known(32'd5, 3, 0, "R5 five");
        t_known(32'h7F00_0800, 33, 5, "R5 mixed runs");
        t_known(32'hFFFF_FFFF, 33, 1, "R6 all ones");
        t_busy_start_R7();
        t_sweep_R11();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule